// File: doc/BRIEF.md
# One-Hot Select Balanced Mux Tree

This block picks one of N data words, each W bits wide, using one select line per word. It contains only combinational logic: no clock, no registers and no latch. The output comes from a balanced binary tree of two-input multiplexers. The select lines are cut in half at each level, and the lower-index half has precedence. A node passes its lower-index branch whenever any select line in that branch is high. Otherwise it passes its upper-index branch.

A parameter can add a fallback word. The fallback sits above the highest data word, and its select is the inverse of the OR of every select line. Because of the tree's shape, every select pattern gives a defined result. With several lines high, the lowest index wins. With none high, the output is the fallback word, or the highest data word when no fallback is built. The block suits decoders whose select may not be strictly one-hot, and places where a wide AND-OR selector would be too deep.

Top module: `ohmux_tree`

## Requirements
- R1: Word i occupies `data_i[i*W +: W]` and is paired with `sel_i[i]`. When exactly one select bit i is high, `y_o` equals word i.
- R2: When several select bits are high, `y_o` equals the word with the lowest asserted index.
- R3: With `USE_DFLT`=1 and `sel_i` all zero, `y_o` equals `dflt_i`.
- R4: With `USE_DFLT`=0 and `sel_i` all zero, `y_o` equals the highest-index word, `data_i[(N-1)*W +: W]`.
- R5: With `USE_DFLT`=0, `dflt_i` has no effect on `y_o` for any select pattern.
- R6: With `USE_DFLT`=1 and at least one select bit high, `dflt_i` has no effect on `y_o`.
- R7: With N=1 and `USE_DFLT`=0, `y_o` equals the single data word whatever `sel_i` is.
- R8: The block is combinational. `y_o` settles to its new value in the same time step as an input change, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_i | input | N | Select lines, one per data word; bit i pairs with word i |
| data_i | input | N*W | Packed data words, word i at bits [i*W +: W] |
| dflt_i | input | W | Fallback word, used only when USE_DFLT=1 |
| y_o | output | W | Selected word |

## Verification
The assertions in the top module run each time an input changes. They check that a one-hot select returns its paired word, that a multi-hot select returns the lowest asserted word, and what the output is for an all-zero select in each fallback mode. They compare the tree's output with a flat scan of the inputs. Only the bench scenarios can show that `dflt_i` is ignored, because that is a claim about two runs with different fallback values, not about one set of inputs. The same holds for the N=1 wire and for the output settling without a clock edge.

// File: rtl/ohmux_pkg.sv
`timescale 1ns/1ps
package ohmux_pkg;
  // Lower-index half of a select group at each tree level.
  function automatic int unsigned left_count(input int unsigned n);
    return n / 2;
  endfunction

  // Remaining entries go to the upper-index half.
  function automatic int unsigned right_count(input int unsigned n);
    return n - (n / 2);
  endfunction
endpackage

// File: rtl/ohmux_or_reduce.sv
`timescale 1ns/1ps
// OR of a select group; a one-bit group is that bit itself.
module ohmux_or_reduce #(
  parameter int unsigned WIDTH = 2
) (
  input  logic [WIDTH-1:0] bits_i,
  output logic             any_o
);
  generate
    if (WIDTH == 1) begin : g_single
      assign any_o = bits_i[0];
    end else begin : g_multi
      assign any_o = |bits_i;
    end
  endgenerate
endmodule

// File: rtl/ohmux_mux2.sv
`timescale 1ns/1ps
// Two-input word multiplexer; the lower-index branch wins when picked.
module ohmux_mux2 #(
  parameter int unsigned W = 8
) (
  input  logic         pick_lo_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    if (pick_lo_i) y_o = lo_i;
    else           y_o = hi_i;
  end
endmodule

// File: rtl/ohmux_node.sv
`timescale 1ns/1ps
// Recursive tree node covering CNT consecutive entries.
module ohmux_node
  import ohmux_pkg::*;
#(
  parameter int unsigned CNT = 2,
  parameter int unsigned W   = 8
) (
  input  logic [CNT-1:0]   sel_i,
  input  logic [CNT*W-1:0] data_i,
  output logic [W-1:0]     y_o
);
  localparam int unsigned LO_N = left_count(CNT);
  localparam int unsigned HI_N = right_count(CNT);

  generate
    if (CNT == 1) begin : g_leaf
      // A leaf passes its word through; its select is consumed one level up.
      logic unused_leaf_sel;
      assign unused_leaf_sel = sel_i[0];
      assign y_o = data_i;
    end else begin : g_split
      logic         lo_any;
      logic [W-1:0] lo_y;
      logic [W-1:0] hi_y;

      ohmux_or_reduce #(.WIDTH(LO_N)) u_lo_or (
        .bits_i (sel_i[LO_N-1:0]),
        .any_o  (lo_any)
      );

      ohmux_node #(.CNT(LO_N), .W(W)) u_lo (
        .sel_i  (sel_i[LO_N-1:0]),
        .data_i (data_i[LO_N*W-1:0]),
        .y_o    (lo_y)
      );

      ohmux_node #(.CNT(HI_N), .W(W)) u_hi (
        .sel_i  (sel_i[CNT-1:LO_N]),
        .data_i (data_i[CNT*W-1:LO_N*W]),
        .y_o    (hi_y)
      );

      ohmux_mux2 #(.W(W)) u_mux (
        .pick_lo_i (lo_any),
        .lo_i      (lo_y),
        .hi_i      (hi_y),
        .y_o       (y_o)
      );
    end
  endgenerate
endmodule

// File: rtl/ohmux_tree.sv
`timescale 1ns/1ps
// Balanced select tree with an optional fallback word.
module ohmux_tree #(
  parameter int unsigned N        = 5,
  parameter int unsigned W        = 8,
  parameter bit          USE_DFLT = 1'b1
) (
  input  logic [N-1:0]   sel_i,
  input  logic [N*W-1:0] data_i,
  input  logic [W-1:0]   dflt_i,
  output logic [W-1:0]   y_o
);
  localparam int unsigned TOT = USE_DFLT ? N + 1 : N;

  logic [TOT-1:0]   ext_sel;
  logic [TOT*W-1:0] ext_data;

  generate
    if (USE_DFLT) begin : g_dflt
      logic sel_any;
      ohmux_or_reduce #(.WIDTH(N)) u_all_or (
        .bits_i (sel_i),
        .any_o  (sel_any)
      );
      assign ext_sel  = {~sel_any, sel_i};
      assign ext_data = {dflt_i, data_i};
    end else begin : g_plain
      logic unused_dflt;
      assign unused_dflt = ^dflt_i;
      assign ext_sel  = sel_i;
      assign ext_data = data_i;
    end
  endgenerate

  ohmux_node #(.CNT(TOT), .W(W)) u_root (
    .sel_i  (ext_sel),
    .data_i (ext_data),
    .y_o    (y_o)
  );

  // Flat scan of the inputs compared with the tree output.
  always_comb begin
    int     lo_idx;
    int     hits;
    logic   found;
    lo_idx = 0;
    hits   = 0;
    found  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel_i[i]) begin
        hits = hits + 1;
        if (!found) begin
          lo_idx = i;
          found  = 1'b1;
        end
      end
    end
    if (!$isunknown({sel_i, data_i, dflt_i, y_o})) begin
      if (hits == 1)
        assert_onehot_pick_R1: assert (y_o == data_i[lo_idx*W +: W])
          else $error("one-hot select did not return its word");
      if (hits > 1)
        assert_lowest_wins_R2: assert (y_o == data_i[lo_idx*W +: W])
          else $error("multi-hot select did not return lowest word");
      if (hits == 0 && USE_DFLT)
        assert_dflt_on_idle_R3: assert (y_o == dflt_i)
          else $error("idle select did not return fallback");
      if (hits == 0 && !USE_DFLT)
        assert_fallthrough_R4: assert (y_o == data_i[(N-1)*W +: W])
          else $error("idle select did not return top word");
    end
  end
endmodule

// File: tb/ohmux_tree_tb.sv
`timescale 1ns/1ps
module ohmux_tree_tb;
  localparam int N = 5;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]   sel;
  logic [N*W-1:0] data;
  logic [W-1:0]   dflt;
  logic [W-1:0]   y_d, y_n;
  logic [0:0]     sel1;
  logic [W-1:0]   data1, dflt1, y_1;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  ohmux_tree #(.N(N), .W(W), .USE_DFLT(1'b1)) u_dut (
    .sel_i(sel), .data_i(data), .dflt_i(dflt), .y_o(y_d));
  ohmux_tree #(.N(N), .W(W), .USE_DFLT(1'b0)) u_dut_nd (
    .sel_i(sel), .data_i(data), .dflt_i(dflt), .y_o(y_n));
  ohmux_tree #(.N(1), .W(W), .USE_DFLT(1'b0)) u_dut_one (
    .sel_i(sel1), .data_i(data1), .dflt_i(dflt1), .y_o(y_1));

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (sel=%b)", req, got, exp, sel);
    end
  endtask

  // Reference: lowest asserted index, else fallback or the top word.
  function automatic logic [W-1:0] pick(logic [N-1:0] s, logic [N*W-1:0] d,
                                        logic [W-1:0] f, bit use_f);
    for (int i = 0; i < N; i++)
      if (s[i]) return d[i*W +: W];
    return use_f ? f : d[(N-1)*W +: W];
  endfunction

  task automatic load_pattern(int seed);
    for (int i = 0; i < N; i++)
      data[i*W +: W] = W'(8'h11 * (i + 1) + seed * 8'h05);
    dflt = W'(8'hE7 ^ seed);
  endtask

  task automatic t_idle;
    sel = '0; data = '0; dflt = '0; sel1 = '0; data1 = '0; dflt1 = '0;
    #2;
    check("R3", y_d, 8'h00);
    check("R4", y_n, 8'h00);
  endtask

  task automatic t_onehot_R1;
    for (int p = 0; p < 2; p++) begin
      load_pattern(p * 7);
      for (int i = 0; i < N; i++) begin
        sel = N'(1) << i;
        #2;
        check("R1", y_d, data[i*W +: W]);
        check("R1", y_n, data[i*W +: W]);
      end
    end
  endtask

  task automatic t_all_patterns_R2;
    load_pattern(3);
    for (int s = 0; s < (1 << N); s++) begin
      sel = N'(s);
      #2;
      check("R2", y_d, pick(sel, data, dflt, 1'b1));
      check("R2", y_n, pick(sel, data, dflt, 1'b0));
    end
    sel = 5'b10110; #2;
    check("R2", y_d, data[1*W +: W]);
    sel = 5'b11111; #2;
    check("R2", y_n, data[0 +: W]);
  endtask

  task automatic t_fallback_R3;
    load_pattern(9);
    sel = '0;
    for (int k = 0; k < 4; k++) begin
      dflt = W'(8'h3C + k * 8'h41);
      #2;
      check("R3", y_d, dflt);
    end
  endtask

  task automatic t_top_word_R4;
    load_pattern(5);
    sel = '0;
    #2;
    check("R4", y_n, data[(N-1)*W +: W]);
  endtask

  task automatic t_dflt_ignored_R5_R6;
    load_pattern(2);
    for (int s = 0; s < (1 << N); s++) begin
      sel  = N'(s);
      dflt = 8'h00; #2;
      check("R5", y_n, pick(sel, data, dflt, 1'b0));
      if (s != 0) check("R6", y_d, pick(sel, data, dflt, 1'b1));
      dflt = 8'hFF; #2;
      check("R5", y_n, pick(sel, data, dflt, 1'b0));
      if (s != 0) check("R6", y_d, pick(sel, data, dflt, 1'b1));
    end
  endtask

  task automatic t_single_R7;
    for (int k = 0; k < 4; k++) begin
      data1 = W'(8'h5A ^ (k * 8'h33));
      dflt1 = ~data1;
      sel1  = k[0];
      #2;
      check("R7", y_1, data1);
    end
  endtask

  task automatic t_comb_R8;
    load_pattern(4);
    @(posedge clk);
    #1;
    sel = 5'b00100;
    #0.1;
    check("R8", y_d, data[2*W +: W]);
    sel = 5'b01000;
    #0.1;
    check("R8", y_n, data[3*W +: W]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_idle();
    t_onehot_R1();
    t_all_patterns_R2();
    t_fallback_R3();
    t_top_word_R4();
    t_dflt_ignored_R5_R6();
    t_single_R7();
    t_comb_R8();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule